// File: doc/BRIEF.md
# Receive PTP Timestamp Capture Latch

This block sits beside a receive parser and records the system time at which a precision-time-protocol event frame arrives. The parser hands it a one-cycle frame-start strobe together with the header fields it has already decoded: ethertype, whether the frame is UDP, the UDP destination port, the PTP version and the message type. A free-running 64-bit system time is supplied on a separate input. When a frame qualifies under the programmed mode, that time is copied into a holding register and a valid flag is raised.

Only one stamp is held. While the flag is set, further qualifying frames are ignored, so software always knows which frame the stored value belongs to. Software reads the low word first and then the high word; the high-word read returns the upper half and releases the latch. Two qualification modes exist: a version-1 mode that accepts only UDP frames of one programmed message type, and a version-2 mode that accepts every event message, over UDP and, when a separate enable is set, directly over Ethernet.

Top module: `ptp_rx_stamp_latch`

## Requirements
- R1: After reset the control word (address 0) reads 0, the filter word (address 1) reads 0x013F0000, and both stamp words (address 2 low, address 3 high) read 0.
- R2: While control bit 0 (enable) is 0, no frame sets the valid flag (control bit 8).
- R3: With control bit 1 clear (version-1 mode), a frame qualifies only if it is UDP, its destination port equals filter bits 31:16, its version is 1 and its message type equals filter bits 3:0; Ethernet-only frames never qualify.
- R4: With control bit 1 set (version-2 mode), a UDP frame with destination port equal to filter bits 31:16 and version 2 qualifies when its message type is 0 to 3, whatever filter bits 3:0 hold; message types 4 and above do not qualify.
- R5: In version-2 mode a non-UDP frame qualifies only when control bit 2 is set, its ethertype is 0x88F7, its version is 2 and its message type is 0 to 3.
- R6: On a qualifying strobe the stored stamp equals the system time input in the strobe cycle; address 2 returns bits 31:0 and address 3 returns bits 63:32.
- R7: While the valid flag is set, a later qualifying frame leaves the stored stamp unchanged.
- R8: A read of address 3 clears the valid flag; a read of address 2 leaves it set.
- R9: Read data appears on the cycle after the read strobe; control bits 2:0 and the full filter word read back as written, and the valid flag cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_start | input | 1 | One-cycle strobe marking a received frame with decoded header |
| frm_ethertype | input | 16 | Ethertype of the frame |
| frm_is_udp | input | 1 | Frame carries UDP |
| frm_udp_port | input | 16 | UDP destination port |
| frm_ptp_ver | input | 4 | PTP version field |
| frm_msg_type | input | 4 | PTP message type field |
| sys_time | input | 64 | Current system time |
| csr_wr | input | 1 | Register write strobe |
| csr_rd | input | 1 | Register read strobe |
| csr_addr | input | 2 | Register address |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data, valid the cycle after csr_rd |

## Verification
The hardest state to reach is a second qualifying frame arriving while a stamp is already held and half read, because it needs a capture, a low-word read and a new frame in that order before the high-word read. The stimulus captures one frame, reads the low word, checks that the flag is still set, sends a qualifying frame carrying a different time, and then reads the high word expecting the first frame's upper half. Version-2 path-delay acceptance is reached by programming a filter type that differs from the frame's type.

// File: rtl/ptp_rx_pkg.sv
package ptp_rx_pkg;
  localparam logic [15:0] ETHTYPE_PTP   = 16'h88F7;
  localparam logic [15:0] EVT_PORT_RST  = 16'd319;
  localparam logic [3:0]  VER_ONE       = 4'd1;
  localparam logic [3:0]  VER_TWO       = 4'd2;
  localparam logic [3:0]  EVT_TYPE_MAX  = 4'd3;

  localparam int CTL_EN_BIT    = 0;
  localparam int CTL_V2_BIT    = 1;
  localparam int CTL_L2_BIT    = 2;
  localparam int CTL_VALID_BIT = 8;

  typedef enum logic [1:0] {
    A_CTRL   = 2'd0,
    A_FILTER = 2'd1,
    A_STAMPL = 2'd2,
    A_STAMPH = 2'd3
  } csr_addr_e;

  typedef struct packed {
    logic l2_en;
    logic v2_mode;
    logic enable;
  } ctl_t;
endpackage

// File: rtl/ptp_rx_qualify.sv
module ptp_rx_qualify
  import ptp_rx_pkg::*;
#(
  parameter int MSG_W  = 4,
  parameter int PORT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  ctl_t              ctl,
  input  logic [PORT_W-1:0] filt_port,
  input  logic [MSG_W-1:0]  filt_type,
  input  logic [15:0]       f_ethertype,
  input  logic              f_is_udp,
  input  logic [PORT_W-1:0] f_port,
  input  logic [3:0]        f_ver,
  input  logic [MSG_W-1:0]  f_type,
  output logic              qual
);
  logic udp_hit, l2_hit, evt_type;

  always_comb begin
    udp_hit  = f_is_udp && (f_port == filt_port);
    l2_hit   = !f_is_udp && ctl.l2_en && (f_ethertype == ETHTYPE_PTP);
    evt_type = (f_type <= MSG_W'(EVT_TYPE_MAX));
    if (ctl.v2_mode)
      qual = (f_ver == VER_TWO) && evt_type && (udp_hit || l2_hit);
    else
      qual = udp_hit && (f_ver == VER_ONE) && (f_type == filt_type);
  end

  // R3: in version-1 mode only the programmed type passes
  p_v1_type_r3: assert property (@(posedge clk) disable iff (rst)
    (qual && !ctl.v2_mode) |-> (f_is_udp && f_type == filt_type));
  // R5: an Ethernet-only frame passes only with the L2 enable set
  p_l2_gate_r5: assert property (@(posedge clk) disable iff (rst)
    (qual && !f_is_udp) |-> (ctl.l2_en && ctl.v2_mode));
endmodule

// File: rtl/ptp_rx_capture.sv
module ptp_rx_capture #(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              strobe,
  input  logic              qual,
  input  logic              release_rd,
  input  logic [TIME_W-1:0] now,
  output logic [TIME_W-1:0] stamp,
  output logic              valid
);
  logic take;

  always_comb take = strobe && qual && enable && !valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      stamp <= '0;
      valid <= 1'b0;
    end else begin
      if (take) stamp <= now;
      if (valid) valid <= !release_rd;
      else       valid <= take;
    end
  end

  // R2: no capture with enable clear
  p_no_cap_disabled_r2: assert property (@(posedge clk) disable iff (rst)
    (!enable && !valid) |=> !valid);
  // R6: captured value is the time of the strobe cycle
  p_capture_time_r6: assert property (@(posedge clk) disable iff (rst)
    (strobe && qual && enable && !valid) |=> (valid && stamp == $past(now)));
  // R7: held stamp is not overwritten
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    valid |=> $stable(stamp));
  // R8: high-word read releases the latch
  p_release_r8: assert property (@(posedge clk) disable iff (rst)
    (valid && release_rd) |=> !valid);
endmodule

// File: rtl/ptp_rx_csr.sv
module ptp_rx_csr
  import ptp_rx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MSG_W  = 4,
  parameter int PORT_W = 16,
  localparam int TIME_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [TIME_W-1:0] stamp,
  input  logic              valid,
  output ctl_t              ctl,
  output logic [PORT_W-1:0] filt_port,
  output logic [MSG_W-1:0]  filt_type,
  output logic              release_rd
);
  localparam logic [DATA_W-1:0] FILT_RST = DATA_W'({EVT_PORT_RST, 16'h0000});

  logic [DATA_W-1:0] filt_q;
  logic [DATA_W-1:0] ctl_word;

  always_comb begin
    filt_port  = filt_q[DATA_W-1 -: PORT_W];
    filt_type  = filt_q[MSG_W-1:0];
    release_rd = rd && (addr == A_STAMPH);
    ctl_word   = '0;
    ctl_word[CTL_EN_BIT]    = ctl.enable;
    ctl_word[CTL_V2_BIT]    = ctl.v2_mode;
    ctl_word[CTL_L2_BIT]    = ctl.l2_en;
    ctl_word[CTL_VALID_BIT] = valid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl    <= '0;
      filt_q <= FILT_RST;
      rdata  <= '0;
    end else begin
      if (wr) begin
        case (addr)
          A_CTRL: begin
            ctl.enable  <= wdata[CTL_EN_BIT];
            ctl.v2_mode <= wdata[CTL_V2_BIT];
            ctl.l2_en   <= wdata[CTL_L2_BIT];
          end
          A_FILTER: filt_q <= wdata;
          default: ;
        endcase
      end
      if (rd) begin
        case (addr)
          A_CTRL:   rdata <= ctl_word;
          A_FILTER: rdata <= filt_q;
          A_STAMPL: rdata <= stamp[DATA_W-1:0];
          default:  rdata <= stamp[TIME_W-1:DATA_W];
        endcase
      end
    end
  end

  // R8: reading the low word keeps the latch held
  p_low_keeps_r8: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == A_STAMPL && valid) |=> valid);
endmodule

// File: rtl/ptp_rx_stamp_latch.sv
module ptp_rx_stamp_latch
  import ptp_rx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MSG_W  = 4,
  parameter int PORT_W = 16,
  localparam int TIME_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_start,
  input  logic [15:0]       frm_ethertype,
  input  logic              frm_is_udp,
  input  logic [PORT_W-1:0] frm_udp_port,
  input  logic [3:0]        frm_ptp_ver,
  input  logic [MSG_W-1:0]  frm_msg_type,
  input  logic [TIME_W-1:0] sys_time,
  input  logic              csr_wr,
  input  logic              csr_rd,
  input  logic [1:0]        csr_addr,
  input  logic [DATA_W-1:0] csr_wdata,
  output logic [DATA_W-1:0] csr_rdata
);
  ctl_t              ctl;
  logic [PORT_W-1:0] filt_port;
  logic [MSG_W-1:0]  filt_type;
  logic              qual, release_rd, valid;
  logic [TIME_W-1:0] stamp;

  ptp_rx_csr #(.DATA_W(DATA_W), .MSG_W(MSG_W), .PORT_W(PORT_W)) u_csr (
    .clk(clk), .rst(rst), .wr(csr_wr), .rd(csr_rd), .addr(csr_addr),
    .wdata(csr_wdata), .rdata(csr_rdata), .stamp(stamp), .valid(valid),
    .ctl(ctl), .filt_port(filt_port), .filt_type(filt_type),
    .release_rd(release_rd)
  );

  ptp_rx_qualify #(.MSG_W(MSG_W), .PORT_W(PORT_W)) u_qual (
    .clk(clk), .rst(rst), .ctl(ctl), .filt_port(filt_port),
    .filt_type(filt_type), .f_ethertype(frm_ethertype),
    .f_is_udp(frm_is_udp), .f_port(frm_udp_port), .f_ver(frm_ptp_ver),
    .f_type(frm_msg_type), .qual(qual)
  );

  ptp_rx_capture #(.TIME_W(TIME_W)) u_cap (
    .clk(clk), .rst(rst), .enable(ctl.enable), .strobe(frm_start),
    .qual(qual), .release_rd(release_rd), .now(sys_time),
    .stamp(stamp), .valid(valid)
  );
endmodule

// File: tb/ptp_rx_stamp_latch_tb_top.sv
module ptp_rx_stamp_latch_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        frm_start;
  logic [15:0] frm_ethertype;
  logic        frm_is_udp;
  logic [15:0] frm_udp_port;
  logic [3:0]  frm_ptp_ver;
  logic [3:0]  frm_msg_type;
  logic [63:0] sys_time;
  logic        csr_wr, csr_rd;
  logic [1:0]  csr_addr;
  logic [31:0] csr_wdata;
  logic [31:0] csr_rdata;

  always #4 clk = ~clk;

  ptp_rx_stamp_latch dut_i (
    .clk(clk), .rst(rst), .frm_start(frm_start), .frm_ethertype(frm_ethertype),
    .frm_is_udp(frm_is_udp), .frm_udp_port(frm_udp_port),
    .frm_ptp_ver(frm_ptp_ver), .frm_msg_type(frm_msg_type),
    .sys_time(sys_time), .csr_wr(csr_wr), .csr_rd(csr_rd),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  // bench model
  logic [2:0]  m_ctl = 3'b000;
  logic [31:0] m_filt = 32'h013F0000;
  logic        m_valid = 1'b0;
  logic [63:0] m_stamp = 64'h0;

  // monitor: compares read data on the cycle after each read strobe
  initial begin
    forever begin
      @(posedge clk);
      if (csr_rd === 1'b1) begin
        #1;
        if (exp_q.size() > 0) begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          n_checks++;
          if (csr_rdata !== e) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", t, csr_rdata, e);
          end
        end
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    frm_start = 0; csr_wr = 0; csr_rd = 0;
  endtask

  task automatic csr_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_wr = 1; csr_addr = a; csr_wdata = d;
    if (a == 2'd0) m_ctl = d[2:0];
    if (a == 2'd1) m_filt = d;
    @(negedge clk);
    csr_wr = 0;
  endtask

  task automatic csr_read(input logic [1:0] a, input string t);
    logic [31:0] e;
    case (a)
      2'd0: e = {23'h0, m_valid, 5'h0, m_ctl};
      2'd1: e = m_filt;
      2'd2: e = m_stamp[31:0];
      default: e = m_stamp[63:32];
    endcase
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    csr_rd = 1; csr_addr = a;
    if (a == 2'd3) m_valid = 1'b0;
    @(negedge clk);
    csr_rd = 0;
  endtask

  function automatic bit model_qual(input logic [15:0] et, input logic udp,
                                    input logic [15:0] port, input logic [3:0] ver,
                                    input logic [3:0] ty);
    bit uhit, lhit;
    uhit = udp && (port == m_filt[31:16]);
    lhit = !udp && m_ctl[2] && (et == 16'h88F7);
    if (m_ctl[1]) return (ver == 4'd2) && (ty <= 4'd3) && (uhit || lhit);
    return uhit && (ver == 4'd1) && (ty == m_filt[3:0]);
  endfunction

  task automatic frame(input logic [15:0] et, input logic udp, input logic [15:0] port,
                       input logic [3:0] ver, input logic [3:0] ty, input logic [63:0] t);
    @(negedge clk);
    frm_start = 1; frm_ethertype = et; frm_is_udp = udp; frm_udp_port = port;
    frm_ptp_ver = ver; frm_msg_type = ty; sys_time = t;
    if (m_ctl[0] && !m_valid && model_qual(et, udp, port, ver, ty)) begin
      m_valid = 1'b1;
      m_stamp = t;
    end
    @(negedge clk);
    frm_start = 0; sys_time = t + 64'd1;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst = 1; frm_start = 0; frm_ethertype = 0; frm_is_udp = 0; frm_udp_port = 0;
    frm_ptp_ver = 0; frm_msg_type = 0; sys_time = 0;
    csr_wr = 0; csr_rd = 0; csr_addr = 0; csr_wdata = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    idle();

    // R1 reset values
    csr_read(2'd0, "R1 ctrl");
    csr_read(2'd1, "R1 filter");
    csr_read(2'd2, "R1 stamp low");
    csr_read(2'd3, "R1 stamp high");

    // R9 readback, valid bit not writable
    csr_write(2'd1, 32'h013F_A5A0);
    csr_read(2'd1, "R9 filter readback");
    csr_write(2'd1, 32'h013F_0000);
    csr_write(2'd0, 32'h0000_0100);
    csr_read(2'd0, "R9 valid not writable");

    // R2 disabled: qualifying frame ignored
    frame(16'h0800, 1, 16'd319, 4'd1, 4'd0, 64'hAAAA_0000_BBBB_0001);
    csr_read(2'd0, "R2 no capture when disabled");

    // R3 version-1 mode, enabled
    csr_write(2'd0, 32'h1);
    frame(16'h0800, 1, 16'd319, 4'd1, 4'd1, 64'h10);
    csr_read(2'd0, "R3 wrong type rejected");
    frame(16'h0800, 1, 16'd319, 4'd2, 4'd0, 64'h20);
    csr_read(2'd0, "R3 wrong version rejected");
    frame(16'h0800, 1, 16'd320, 4'd1, 4'd0, 64'h30);
    csr_read(2'd0, "R3 wrong port rejected");
    frame(16'h88F7, 0, 16'd0, 4'd1, 4'd0, 64'h40);
    csr_read(2'd0, "R3 layer-2 rejected in v1");
    frame(16'h0800, 1, 16'd319, 4'd1, 4'd0, 64'h1122_3344_5566_7788);
    csr_read(2'd0, "R3 matching frame sets valid");

    // R6/R7/R8 lock and read order
    csr_read(2'd2, "R6 low word");
    csr_read(2'd0, "R8 low read keeps valid");
    frame(16'h0800, 1, 16'd319, 4'd1, 4'd0, 64'h9999_9999_9999_9999);
    csr_read(2'd2, "R7 low unchanged while locked");
    csr_read(2'd3, "R6 high word");
    csr_read(2'd0, "R8 high read clears valid");

    // R4 version-2 mode with filter type 0: pdelay type 2 accepted
    csr_write(2'd0, 32'h3);
    frame(16'h0800, 1, 16'd319, 4'd2, 4'd8, 64'h50);
    csr_read(2'd0, "R4 general message rejected");
    frame(16'h0800, 1, 16'd319, 4'd2, 4'd2, 64'hCAFE_0001_DEAD_0002);
    csr_read(2'd0, "R4 path-delay sets valid");
    csr_read(2'd2, "R4 low word");
    csr_read(2'd3, "R4 high word");

    // R5 layer-2 frames
    frame(16'h88F7, 0, 16'd0, 4'd2, 4'd0, 64'h60);
    csr_read(2'd0, "R5 layer-2 rejected without enable");
    csr_write(2'd0, 32'h7);
    frame(16'h88F6, 0, 16'd0, 4'd2, 4'd0, 64'h70);
    csr_read(2'd0, "R5 wrong ethertype rejected");
    frame(16'h88F7, 0, 16'd0, 4'd2, 4'd1, 64'h0000_0777_0000_0888);
    csr_read(2'd0, "R5 layer-2 sets valid");
    csr_read(2'd2, "R5 low word");
    csr_read(2'd3, "R5 high word");
    csr_read(2'd0, "R8 cleared after layer-2 read");

    repeat (3) idle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule